// File: doc/BRIEF.md
# Precision Ranging Code Generator

This block produces the long precision ranging code, one chip per enabled clock, for a selected satellite index. The chip clock runs ten times faster than the short coarse code clock, giving 10.23 Mchip/s. Two sequences of slightly different length are built. The first, X1, comes from two 12-bit feedback registers. The second, X2, comes from two more 12-bit feedback registers. Each register is cut short by a position counter, and a cycle counter decides when it stops and holds.

X1 repeats every 15,345,000 chips, which is 1.5 s. X2 repeats every 15,345,037 chips. The code for satellite i is X1 at the current chip XORed with X2 as it was i chips earlier. A small history of X2 bits supplies the i-chip delay, for i from 1 to 37. A one-clock strobe marks the start of each X1 period.

Each register pair has its own controller with three named states:
- `PH_RUN`: both registers step. It moves to `PH_B_HOLD` when the B register ends its last allowed short cycle.
- `PH_B_HOLD`: the A register steps while B holds its start value. When A ends its last short cycle, the controller returns to `PH_RUN` if the pair has no extra hold, or goes to `PH_ALL_HOLD` if it has one.
- `PH_ALL_HOLD`: both registers hold. After the extra-hold count of enabled chips, the controller returns to `PH_RUN` and the period ends.

The X1 pair has no extra hold. The X2 pair has an extra hold of 37 chips.

Top module: `pcode_gen`

## Requirements
- R1: A synchronous reset (`rst` high) loads the four registers with their start values. It clears the chip history and the strobe. After reset the code equals the X1 bit of chip 0 for any valid index.
- R2: While `ce` is low, no register, counter or history moves. With `sat_idx` unchanged, `code_o` keeps its value.
- R3: Each register shifts left one place per enabled chip. The new stage 1 is the XOR of its tap stages, and stage 12 (bit 11) is its output. X1A uses taps 6, 8, 11, 12 and starts at 001001001000. X1B uses taps 1, 2, 5, 8, 9, 10, 11, 12 and starts at 010101010100. X2A uses taps 1, 3, 4, 5, 7, 8, 9, 10, 11, 12 and starts at 100100100101. X2B uses taps 2, 3, 4, 8, 9, 12 and starts at 010101010100. The start values are written with stage 12 leftmost.
- R4: Both A registers reload their start value after 4092 chips, and both B registers after 4093 chips.
- R5: The X1 bit is the XOR of the X1A and X1B outputs. X1B stops at its start value after 3749 short cycles and stays there until X1A completes 3750 short cycles. The X1 period is therefore 15,345,000 chips.
- R6: The X2 bit is the XOR of the X2A and X2B outputs. X2A and X2B use the same cycle counts as the X1 pair. After X2A's last cycle, both X2 registers then hold at their start values for 37 more chips, so the X2 period is 15,345,037 chips.
- R7: For `sat_idx` from 1 to 37, `code_o` equals X1(n) XOR X2(n − sat_idx), where n is the number of enabled chips since reset. X2 bits from before reset count as 0. The index selects combinationally.
- R8: For `sat_idx` equal to 0 or above 37, `code_o` is 0.
- R9: `epoch_o` is high for exactly the one clock that follows the enabled edge which completes an X1 period. At that point X1A and X1B both hold their start values.
- R10: A reset asserted mid-run restarts the chip count at 0 and clears the history, with the same result as the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable: one chip per clock while high |
| sat_idx | input | 6 | Satellite index; 1 to 37 selects the X2 delay in chips |
| code_o | output | 1 | Ranging code chip for the selected index |
| epoch_o | output | 1 | One-clock strobe at the start of each X1 period |

## Verification
The bench shortens only the cycle counts, to 4 and 3, and keeps the real 4092 and 4093 chip lengths. This means the register wraps, the B hold, the 37-chip X2 hold and several X1 epochs all occur within one run.

The code is tried under three input patterns:
- A continuous enable with the index swept across every value, including 0 and the out-of-range values. This separates the delay selection from the X1/X2 content.
- An irregular enable. This shows whether a held chip ever advances a register, a counter or the history.
- A mid-run reset. This shows whether the history and the counters restart together.

Because X2 drifts 37 chips against X1 on every epoch, a comparison after the second epoch can only pass if the X2 extra hold is exactly right.

// File: rtl/pcode_pkg.sv
package pcode_pkg;

    localparam int REG_W = 12;
    localparam int NUM_REGS = 4;

    // Feedback tap masks: bit k-1 set for tap stage k
    localparam logic [REG_W-1:0] TAP_MASK [NUM_REGS] = '{
        12'hCA0,    // X1A: 6 8 11 12
        12'hF93,    // X1B: 1 2 5 8 9 10 11 12
        12'hFDD,    // X2A: 1 3 4 5 7 8 9 10 11 12
        12'h98E     // X2B: 2 3 4 8 9 12
    };

    // Start values, stage 12 in the most significant bit
    localparam logic [REG_W-1:0] START_VAL [NUM_REGS] = '{
        12'b001001001000,
        12'b010101010100,
        12'b100100100101,
        12'b010101010100
    };

    typedef enum logic [1:0] {
        PH_RUN,
        PH_B_HOLD,
        PH_ALL_HOLD
    } pair_phase_e;

endpackage

// File: rtl/pcode_lfsr12.sv
module pcode_lfsr12 #(
    parameter int W = 12,
    parameter logic [W-1:0] TAPS = '0,
    parameter logic [W-1:0] START = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         load,
    output logic [W-1:0] q,
    output logic         bit_o
);

    logic fb;

    always_comb begin
        fb = ^(q & TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            q <= START;
        end else if (step) begin
            q <= {q[W-2:0], fb};
        end
    end

    assign bit_o = q[W-1];

endmodule

// File: rtl/pcode_pair_ctrl.sv
module pcode_pair_ctrl
    import pcode_pkg::*;
#(
    parameter int LEN_A = 4092,
    parameter int LEN_B = 4093,
    parameter int CYC_A = 3750,
    parameter int CYC_B = 3749,
    parameter int EXTRA = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce,
    output logic        step_a,
    output logic        load_a,
    output logic        step_b,
    output logic        load_b,
    output logic        period_end,
    output pair_phase_e phase
);

    localparam int PA_W = $clog2(LEN_A);
    localparam int PB_W = $clog2(LEN_B);
    localparam int CA_W = $clog2(CYC_A + 1);
    localparam int CB_W = $clog2(CYC_B + 1);
    localparam int XC_W = $clog2(EXTRA + 2);

    logic [PA_W-1:0] pos_a;
    logic [PB_W-1:0] pos_b;
    logic [CA_W-1:0] cyc_a;
    logic [CB_W-1:0] cyc_b;
    logic [XC_W-1:0] xcnt;

    pair_phase_e phase_q, phase_d;
    logic adv_a, adv_b;
    logic last_a, last_b, final_a, final_b, xdone;

    assign last_a  = (int'(pos_a) == LEN_A - 1);
    assign last_b  = (int'(pos_b) == LEN_B - 1);
    assign final_a = last_a && (int'(cyc_a) == CYC_A - 1);
    assign final_b = last_b && (int'(cyc_b) == CYC_B - 1);
    assign xdone   = (int'(xcnt) == EXTRA - 1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next state and outputs
    always_comb begin
        phase_d    = phase_q;
        adv_a      = 1'b0;
        adv_b      = 1'b0;
        period_end = 1'b0;
        unique case (phase_q)
            PH_RUN: begin
                adv_a = ce;
                adv_b = ce;
                if (ce && final_b) begin
                    phase_d = PH_B_HOLD;
                end
            end
            PH_B_HOLD: begin
                adv_a = ce;
                if (ce && final_a) begin
                    if (EXTRA == 0) begin
                        phase_d    = PH_RUN;
                        period_end = 1'b1;
                    end else begin
                        phase_d = PH_ALL_HOLD;
                    end
                end
            end
            PH_ALL_HOLD: begin
                if (ce && xdone) begin
                    phase_d    = PH_RUN;
                    period_end = 1'b1;
                end
            end
            default: phase_d = PH_RUN;
        endcase
    end

    assign step_a = adv_a && !last_a;
    assign load_a = adv_a && last_a;
    assign step_b = adv_b && !last_b;
    assign load_b = adv_b && last_b;
    assign phase  = phase_q;

    // Position and cycle counters
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_a <= '0;
            cyc_a <= '0;
        end else if (adv_a) begin
            pos_a <= last_a ? '0 : pos_a + 1'b1;
            if (last_a) begin
                cyc_a <= final_a ? '0 : cyc_a + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_b <= '0;
            cyc_b <= '0;
        end else if (adv_b) begin
            pos_b <= last_b ? '0 : pos_b + 1'b1;
            if (last_b) begin
                cyc_b <= final_b ? '0 : cyc_b + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xcnt <= '0;
        end else if (phase_q == PH_ALL_HOLD && ce) begin
            xcnt <= xdone ? '0 : xcnt + 1'b1;
        end
    end

endmodule

// File: rtl/pcode_delay.sv
module pcode_delay #(
    parameter int DEPTH = 37,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             din,
    input  logic [IDX_W-1:0] idx,
    output logic             tap,
    output logic             tap_ok
);

    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (ce) begin
            hist <= {hist[DEPTH-2:0], din};
        end
    end

    always_comb begin
        tap_ok = (idx != '0) && (int'(idx) <= DEPTH);
        tap    = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(idx) == k) begin
                tap = hist[k-1];
            end
        end
    end

endmodule

// File: rtl/pcode_gen.sv
module pcode_gen
    import pcode_pkg::*;
#(
    parameter int LEN_A     = 4092,
    parameter int LEN_B     = 4093,
    parameter int CYC_A     = 3750,
    parameter int CYC_B     = 3749,
    parameter int X2_EXTRA  = 37,
    parameter int MAX_DELAY = 37
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ce,
    input  logic [$clog2(MAX_DELAY+1)-1:0] sat_idx,
    output logic                           code_o,
    output logic                           epoch_o
);

    localparam int IDX_W = $clog2(MAX_DELAY + 1);

    logic [REG_W-1:0] lfsr_q   [NUM_REGS];
    logic             lfsr_bit [NUM_REGS];
    logic             reg_step [NUM_REGS];
    logic             reg_load [NUM_REGS];
    logic             pend     [2];
    pair_phase_e      pphase   [2];

    logic x1_bit, x2_bit, x2_tap, tap_ok, epoch_q;

    // Pair 0 forms X1, pair 1 forms X2 (with an extra hold)
    for (genvar p = 0; p < 2; p++) begin : g_pair
        pcode_pair_ctrl #(
            .LEN_A(LEN_A),
            .LEN_B(LEN_B),
            .CYC_A(CYC_A),
            .CYC_B(CYC_B),
            .EXTRA((p == 0) ? 0 : X2_EXTRA)
        ) u_ctrl (
            .clk       (clk),
            .rst       (rst),
            .ce        (ce),
            .step_a    (reg_step[2*p]),
            .load_a    (reg_load[2*p]),
            .step_b    (reg_step[2*p+1]),
            .load_b    (reg_load[2*p+1]),
            .period_end(pend[p]),
            .phase     (pphase[p])
        );
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        pcode_lfsr12 #(
            .W    (REG_W),
            .TAPS (TAP_MASK[g]),
            .START(START_VAL[g])
        ) u_lfsr (
            .clk  (clk),
            .rst  (rst),
            .step (reg_step[g]),
            .load (reg_load[g]),
            .q    (lfsr_q[g]),
            .bit_o(lfsr_bit[g])
        );
    end

    assign x1_bit = lfsr_bit[0] ^ lfsr_bit[1];
    assign x2_bit = lfsr_bit[2] ^ lfsr_bit[3];

    pcode_delay #(
        .DEPTH(MAX_DELAY),
        .IDX_W(IDX_W)
    ) u_delay (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .din   (x2_bit),
        .idx   (sat_idx),
        .tap   (x2_tap),
        .tap_ok(tap_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epoch_q <= 1'b0;
        end else begin
            epoch_q <= pend[0];
        end
    end

    assign code_o  = tap_ok & (x1_bit ^ x2_tap);
    assign epoch_o = epoch_q;

endmodule

// File: rtl/pcode_gen_chk.sv
module pcode_gen_chk
    import pcode_pkg::*;
#(
    parameter int MAX_DELAY = 37
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ce,
    input logic [$clog2(MAX_DELAY+1)-1:0] sat_idx,
    input logic                           code_o,
    input logic                           epoch_o,
    input logic [REG_W-1:0]               x1a_q,
    input logic [REG_W-1:0]               x1b_q,
    input logic [REG_W-1:0]               x2a_q,
    input logic [REG_W-1:0]               x2b_q,
    input pair_phase_e                    x2_phase
);

    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q && rst) begin
            reset_init_chk: assert (x1a_q == START_VAL[0] && x1b_q == START_VAL[1]
                                    && x2a_q == START_VAL[2] && x2b_q == START_VAL[3]);
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(x1a_q) && $stable(x1b_q) && $stable(x2a_q) && $stable(x2b_q)));

    // R6
    x2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (x2_phase == PH_ALL_HOLD) |=> ($stable(x2a_q) && $stable(x2b_q)));

    // R8
    bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
        ((sat_idx == '0) || (int'(sat_idx) > MAX_DELAY)) |-> !code_o);

    // R9
    epoch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        epoch_o |=> !epoch_o);

    // R9
    epoch_state_chk: assert property (@(posedge clk) disable iff (rst)
        epoch_o |-> (x1a_q == START_VAL[0] && x1b_q == START_VAL[1]));

endmodule

bind pcode_gen pcode_gen_chk #(.MAX_DELAY(MAX_DELAY)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .sat_idx (sat_idx),
    .code_o  (code_o),
    .epoch_o (epoch_o),
    .x1a_q   (lfsr_q[0]),
    .x1b_q   (lfsr_q[1]),
    .x2a_q   (lfsr_q[2]),
    .x2b_q   (lfsr_q[3]),
    .x2_phase(pphase[1])
);

// File: tb/pcode_gen_tb.sv
module pcode_gen_tb;

    localparam int LA = 4092;
    localparam int LB = 4093;
    localparam int CA = 4;
    localparam int CB = 3;
    localparam int XH = 37;
    localparam int MD = 37;
    localparam int P1 = CA * LA;
    localparam int P2 = P1 + XH;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b0;
    logic [5:0] sat_idx = 6'd1;
    logic       code_o, epoch_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pcode_gen #(
        .LEN_A(LA), .LEN_B(LB), .CYC_A(CA), .CYC_B(CB),
        .X2_EXTRA(XH), .MAX_DELAY(MD)
    ) u_dut (
        .clk(clk), .rst(rst), .ce(ce), .sat_idx(sat_idx),
        .code_o(code_o), .epoch_o(epoch_o)
    );

    // Short-cycle output sequences, one per register (R3 R4)
    bit seq [4][4096];

    function automatic void build(int r, int len, int taps[$], bit [11:0] start);
        bit st [13];
        for (int k = 1; k <= 12; k++) st[k] = start[k-1];
        for (int c = 0; c < len; c++) begin
            bit fb = 1'b0;
            seq[r][c] = st[12];
            foreach (taps[t]) fb ^= st[taps[t]];
            for (int k = 12; k >= 2; k--) st[k] = st[k-1];
            st[1] = fb;
        end
    endfunction

    // R5: X1 with B held at its start value after CB cycles
    function automatic bit x1(longint n);
        longint m = n % P1;
        bit a = seq[0][m % LA];
        bit b = (m < CB * LB) ? seq[1][m % LB] : seq[1][0];
        return a ^ b;
    endfunction

    // R6: X2 with the extra 37-chip hold
    function automatic bit x2(longint n);
        longint m = n % P2;
        bit a = (m < CA * LA) ? seq[2][m % LA] : seq[2][0];
        bit b = (m < CB * LB) ? seq[3][m % LB] : seq[3][0];
        return a ^ b;
    endfunction

    longint n_chip = 0;
    bit     ep_exp = 1'b0;
    bit     ce_low_seen = 1'b0;
    string  tag = "R1";

    task automatic compare();
        bit exp_c;
        int i = int'(sat_idx);
        if (i >= 1 && i <= MD) begin
            exp_c = x1(n_chip) ^ ((n_chip - i >= 0) ? x2(n_chip - i) : 1'b0);
        end else begin
            exp_c = 1'b0;
        end
        compared++;
        if (code_o !== exp_c) begin
            mismatched++;
            $display("FAIL %s (R7 R8) code chip %0d idx %0d: got %b exp %b",
                     tag, n_chip, i, code_o, exp_c);
        end
        compared++;
        if (epoch_o !== ep_exp) begin
            mismatched++;
            $display("FAIL R9 epoch chip %0d: got %b exp %b", n_chip, epoch_o, ep_exp);
        end
    endtask

    task automatic tick(bit ce_v, int idx_v, bit rst_v);
        @(negedge clk);
        ce = ce_v;
        rst = rst_v;
        sat_idx = 6'(idx_v);
        #1;
        if (!rst_v) compare();
        @(posedge clk);
        if (rst_v) begin
            n_chip = 0;
            ep_exp = 1'b0;
        end else if (ce_v) begin
            n_chip++;
            ep_exp = (n_chip % P1 == 0);
        end else begin
            ep_exp = 1'b0;
        end
    endtask

    initial begin
        build(0, LA, '{6, 8, 11, 12}, 12'b001001001000);
        build(1, LB, '{1, 2, 5, 8, 9, 10, 11, 12}, 12'b010101010100);
        build(2, LA, '{1, 3, 4, 5, 7, 8, 9, 10, 11, 12}, 12'b100100100101);
        build(3, LB, '{2, 3, 4, 8, 9, 12}, 12'b010101010100);

        // R1: reset state, then first chips
        for (int c = 0; c < 3; c++) tick(1'b0, 5, 1'b1);
        tag = "R1";
        tick(1'b0, 5, 1'b0);
        tick(1'b0, 37, 1'b0);

        // R3 R4 R5 R6 R7: continuous enable, index sweep incl. 0 and out of range (R8)
        tag = "R7 (R3 R4 R5 R6)";
        for (int c = 0; c < 52000; c++) tick(1'b1, (c / 97) % 64, 1'b0);

        // R2: irregular enable; held chips must not move anything
        tag = "R2";
        for (int c = 0; c < 30000; c++) begin
            bit e = ((c * 7 + c / 5) % 10) < 7;
            tick(e, 1 + (c / 53) % MD, 1'b0);
        end

        // R10: mid-run reset restarts count and clears history
        tick(1'b1, 1, 1'b1);
        tick(1'b1, 1, 1'b1);
        tag = "R10";
        for (int c = 0; c < 20000; c++) tick(1'b1, (c % 3 == 0) ? 37 : 1 + c % MD, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            mismatched++;
            $display("FAIL watchdog: got %0d cycles exp < 190000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule